// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

This block is a 16-bit timer/counter peripheral on a byte-wide register bus. It counts one of two sources. The first is an internal tick that fires once every twelve clock cycles. The second is the falling edges of an external count pin. An external trigger pin can capture the running count into a 16-bit holding pair, or it can load the counter from that pair. When the counter passes its all-ones value, it either wraps to zero or reloads.

In baud mode, the counter always reloads and its overflow strobes are sent to a serial port as receive and/or transmit clock ticks. The overflow flag is held off in this mode. A serial direction that is not assigned to this timer receives an external overflow strobe from another timer instead.

Two sticky flags record overflow and trigger events, and they form an interrupt request. A trigger flag can be masked from the interrupt by a mode bit. Software clears each flag by writing zero to it. Register writes take effect on the next cycle. A hardware event in the same cycle as a conflicting write wins over the write.

Top module: `capReloadTimer`

## Requirements
- R1: After reset, every register reads 0x00, and irq, rxBaudTick and txBaudTick are low.
- R2: Timer mode is selected with control bits run (bit 2) = 1 and source select (bit 1) = 0. In this mode the counter advances by one on every twelfth clock edge after run is written.
- R3: With run = 1 and source select = 1, the counter advances by one for each falling edge on cntPin. The change is visible three clock edges after the pin falls. Rising edges have no effect.
- R4: With run = 0, the counter holds its value.
- R5: In capture mode (control bit 0 = 1, both baud selects 0), an overflow from 0xFFFF wraps the counter to 0x0000 and sets the overflow flag (control bit 7). The flag stays set until a control write puts 0 in bit 7.
- R6: In reload mode (control bit 0 = 0), an overflow loads the counter from the holding pair (low byte at 0xCA, high byte at 0xCB) and sets the overflow flag.
- R7: In capture mode with trigger enable (control bit 3) = 1, a falling edge on trigPin copies the counter into the holding pair and sets the trigger flag (control bit 6). The counter is left unchanged.
- R8: In reload mode with trigger enable = 1, a falling edge on trigPin loads the counter from the holding pair and sets the trigger flag.
- R9: With trigger enable = 0, trigPin edges change neither the flags, nor the counter, nor the holding pair.
- R10: When receive-baud select (bit 5) or transmit-baud select (bit 4) is 1:
  - the counter reloads on every overflow, whatever bit 0 holds;
  - the overflow flag is not set;
  - a one-cycle pulse appears on the selected baud output one clock after the overflow;
  - a trigger edge with trigger enable set raises the trigger flag but neither captures nor reloads.
- R11: Each baud output whose select is 0 carries t1OvfIn delayed by one clock.
- R12: irq is high when irqEn = 1 and either the overflow flag is set or the trigger flag is set while mode bit 0 (trigger-interrupt mask) is 0.
- R13: The register map is: control 0xC8; mode 0xC9 (bits 1:0 kept, bits 7:2 read 0); holding pair 0xCA/0xCB; counter 0xCC/0xCD. A counter write in the same cycle as a trigger reload is dropped. A flag-clearing control write in the same cycle as a trigger event leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| cntPin | input | 1 | External count source, falling-edge active |
| trigPin | input | 1 | External capture/reload trigger, falling-edge active |
| t1OvfIn | input | 1 | Overflow strobe from another timer, used for unselected baud directions |
| irqEn | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| rxBaudTick | output | 1 | Receive baud clock tick |
| txBaudTick | output | 1 | Transmit baud clock tick |

## Verification
The assertions assume that cntPin and trigPin stay at each level for at least three clock cycles, so that every falling edge reaches the edge detector as one clean transition. They also assume that addr and wrData are stable while wrEn is high. The stimulus drives every input on the falling clock edge. It holds each pin level for at least three cycles before changing it, and it lowers wrEn on the cycle after every write. The race cases are produced by counting the synchronizer cycles exactly, so that a write lands on the same edge as the trigger event.

// File: rtl/capTmrPkg.sv
package capTmrPkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  // control register bit positions (software decodes these)
  localparam int BIT_OVF     = 7;
  localparam int BIT_EXT     = 6;
  localparam int BIT_RXSEL   = 5;
  localparam int BIT_TXSEL   = 4;
  localparam int BIT_EXTEN   = 3;
  localparam int BIT_RUN     = 2;
  localparam int BIT_SRCSEL  = 1;
  localparam int BIT_CAPMODE = 0;

  // mode register bit positions
  localparam int BIT_EXTMASK = 0;
  localparam int BIT_OUTEN   = 1;
  localparam int MODE_W      = 2;

  typedef struct packed {
    logic countTick;
    logic trigEvt;
  } tmrStrobe_t;

  typedef struct packed {
    logic run;
    logic extSel;
    logic extEn;
  } tmrCfg_t;
endpackage

// File: rtl/capTmrEdge.sv
module capTmrEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic fallPulse
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], pinIn};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign fallPulse = prevQ & ~syncQ[STAGES-1];

  // R3
  single_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse |=> !fallPulse);
endmodule

// File: rtl/capTmrCtrl.sv
module capTmrCtrl
  import capTmrPkg::*;
#(
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrCfg_t    cfg,
  input  logic       cntPin,
  input  logic       trigPin,
  output tmrStrobe_t stb
);
  localparam int PW    = $clog2(DIV);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pinVec;
  logic [NPINS-1:0] fallVec;
  assign pinVec = {trigPin, cntPin};

  for (genvar i = 0; i < NPINS; i++) begin : g_edge
    capTmrEdge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rstN     (rstN),
      .pinIn    (pinVec[i]),
      .fallPulse(fallVec[i])
    );
  end

  logic [PW-1:0] presc;
  logic          prescWrap;
  assign prescWrap = (presc == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else if (!cfg.run || cfg.extSel || prescWrap) presc <= '0;
    else presc <= presc + PW'(1);
  end

  assign stb.countTick = cfg.run & (cfg.extSel ? fallVec[0] : prescWrap);
  assign stb.trigEvt   = cfg.extEn & fallVec[1];

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countTick && !cfg.extSel) |=> !stb.countTick);

  // R4
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.run |-> !stb.countTick);
endmodule

// File: rtl/capTmrDatapath.sv
module capTmrDatapath
  import capTmrPkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'hC8,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'hC9,
  parameter logic [ADDR_W-1:0] RLD_LO_ADDR = 8'hCA,
  parameter logic [ADDR_W-1:0] RLD_HI_ADDR = 8'hCB,
  parameter logic [ADDR_W-1:0] CNT_LO_ADDR = 8'hCC,
  parameter logic [ADDR_W-1:0] CNT_HI_ADDR = 8'hCD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  tmrStrobe_t        stb,
  output tmrCfg_t           cfg,
  input  logic              t1OvfIn,
  input  logic              irqEn,
  output logic              irq,
  output logic              rxBaudTick,
  output logic              txBaudTick
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [BYTE_W-1:0] ctrlQ;
  logic [MODE_W-1:0] modeQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  rldQ;
  logic              rxTickQ, txTickQ;

  logic ctrlWr, modeWr, rldLoWr, rldHiWr, cntLoWr, cntHiWr;
  assign ctrlWr  = wrEn && (addr == CTRL_ADDR);
  assign modeWr  = wrEn && (addr == MODE_ADDR);
  assign rldLoWr = wrEn && (addr == RLD_LO_ADDR);
  assign rldHiWr = wrEn && (addr == RLD_HI_ADDR);
  assign cntLoWr = wrEn && (addr == CNT_LO_ADDR);
  assign cntHiWr = wrEn && (addr == CNT_HI_ADDR);

  logic rxSel, txSel, baudMode, capMode, reloadMode;
  assign rxSel      = ctrlQ[BIT_RXSEL];
  assign txSel      = ctrlQ[BIT_TXSEL];
  assign baudMode   = rxSel | txSel;
  assign capMode    = ctrlQ[BIT_CAPMODE];
  assign reloadMode = baudMode | ~capMode;

  assign cfg.run    = ctrlQ[BIT_RUN];
  assign cfg.extSel = ctrlQ[BIT_SRCSEL];
  assign cfg.extEn  = ctrlQ[BIT_EXTEN];

  logic ovfHit, ovfSet, extSet, capEvt, ldEvt;
  assign ovfHit = stb.countTick && (cntQ == MAXV);
  assign ovfSet = ovfHit & ~baudMode;
  assign extSet = stb.trigEvt;
  assign capEvt = stb.trigEvt & capMode & ~baudMode;
  assign ldEvt  = stb.trigEvt & ~capMode & ~baudMode;

  // control register: hardware flag set beats a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= wrData;
      if (ovfSet) ctrlQ[BIT_OVF] <= 1'b1;
      if (extSet) ctrlQ[BIT_EXT] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       modeQ <= '0;
    else if (modeWr) modeQ <= wrData[MODE_W-1:0];
  end

  // counter: hardware events win over software byte writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ldEvt) begin
      cntQ <= rldQ;
    end else if (stb.countTick) begin
      if (cntQ == MAXV) cntQ <= reloadMode ? rldQ : '0;
      else              cntQ <= cntQ + CNT_W'(1);
    end else begin
      if (cntLoWr) cntQ[BYTE_W-1:0]     <= wrData;
      if (cntHiWr) cntQ[CNT_W-1:BYTE_W] <= wrData;
    end
  end

  // holding pair: capture wins over software byte writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rldQ <= '0;
    end else if (capEvt) begin
      rldQ <= cntQ;
    end else begin
      if (rldLoWr) rldQ[BYTE_W-1:0]     <= wrData;
      if (rldHiWr) rldQ[CNT_W-1:BYTE_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxTickQ <= 1'b0;
      txTickQ <= 1'b0;
    end else begin
      rxTickQ <= rxSel ? ovfHit : t1OvfIn;
      txTickQ <= txSel ? ovfHit : t1OvfIn;
    end
  end

  assign rxBaudTick = rxTickQ;
  assign txBaudTick = txTickQ;
  assign irq = irqEn & (ctrlQ[BIT_OVF] | (ctrlQ[BIT_EXT] & ~modeQ[BIT_EXTMASK]));

  always_comb begin
    rdData = '0;
    case (addr)
      CTRL_ADDR:   rdData = ctrlQ;
      MODE_ADDR:   rdData = {{(BYTE_W-MODE_W){1'b0}}, modeQ};
      RLD_LO_ADDR: rdData = rldQ[BYTE_W-1:0];
      RLD_HI_ADDR: rdData = rldQ[CNT_W-1:BYTE_W];
      CNT_LO_ADDR: rdData = cntQ[BYTE_W-1:0];
      CNT_HI_ADDR: rdData = cntQ[CNT_W-1:BYTE_W];
      default:     rdData = '0;
    endcase
  end

  // R4
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.run && !stb.trigEvt && !cntLoWr && !cntHiWr) |=> $stable(cntQ));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[BIT_OVF] && !ctrlWr) |=> ctrlQ[BIT_OVF]);

  // R10
  baud_no_ovf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (baudMode && !ctrlWr) |=> $stable(ctrlQ[BIT_OVF]));

  // R7
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    capEvt |=> (rldQ == $past(cntQ)));

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ctrlQ[BIT_OVF]) |-> !modeQ[BIT_EXTMASK]);
endmodule

// File: rtl/capReloadTimer.sv
module capReloadTimer
  import capTmrPkg::*;
#(
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       cntPin,
  input  logic       trigPin,
  input  logic       t1OvfIn,
  input  logic       irqEn,
  output logic       irq,
  output logic       rxBaudTick,
  output logic       txBaudTick
);
  tmrStrobe_t stb;
  tmrCfg_t    cfg;

  capTmrCtrl #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfg),
    .cntPin (cntPin),
    .trigPin(trigPin),
    .stb    (stb)
  );

  capTmrDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rdData    (rdData),
    .stb       (stb),
    .cfg       (cfg),
    .t1OvfIn   (t1OvfIn),
    .irqEn     (irqEn),
    .irq       (irq),
    .rxBaudTick(rxBaudTick),
    .txBaudTick(txBaudTick)
  );
endmodule

// File: tb/capReloadTimer_tb.sv
`timescale 1ns/100ps
module capReloadTimer_tb;
  localparam logic [7:0] A_CTRL = 8'hC8, A_MODE = 8'hC9, A_RLO = 8'hCA,
                         A_RHI = 8'hCB, A_CLO = 8'hCC, A_CHI = 8'hCD;
  localparam int S_RD = 0, S_IRQ = 1, S_RX = 2, S_TX = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic cntPin = 1'b1, trigPin = 1'b1, t1OvfIn = 1'b0, irqEn = 1'b0;
  logic irq, rxBaudTick, txBaudTick;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  string reqQ[$];
  int    selQ[$];
  int    expQ[$];

  always #4 clk = ~clk;

  capReloadTimer u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cntPin(cntPin), .trigPin(trigPin), .t1OvfIn(t1OvfIn),
    .irqEn(irqEn), .irq(irq), .rxBaudTick(rxBaudTick), .txBaudTick(txBaudTick)
  );

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      wait (expQ.size() > 0);
      #0.5;
      begin
        string r;
        int s, e, act;
        r = reqQ.pop_front();
        s = selQ.pop_front();
        e = expQ.pop_front();
        case (s)
          S_IRQ:   act = int'(irq);
          S_RX:    act = int'(rxBaudTick);
          S_TX:    act = int'(txBaudTick);
          default: act = int'(rdData);
        endcase
        checks++;
        if (act != e) begin
          errors++;
          $display("FAIL %s: actual=%0h expected=%0h", r, act, e);
        end
      end
    end
  end

  // driver side: push an expected item, wait for the monitor to consume it
  task automatic expectVal(input string req, input int sel, input logic [7:0] a, input int e);
    if (sel == S_RD) addr = a;
    reqQ.push_back(req);
    selQ.push_back(sel);
    expQ.push_back(e);
    wait (expQ.size() == 0);
  endtask

  task automatic writeNow(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    writeNow(a, d);
  endtask

  // falling edge on a pin, event visible at return; then rise and settle
  task automatic pulseFall(input bit useTrig);
    @(negedge clk);
    if (useTrig) trigPin = 1'b0; else cntPin = 1'b0;
    repeat (3) @(negedge clk);
    if (useTrig) trigPin = 1'b1; else cntPin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectVal("R1 ctrl", S_RD, A_CTRL, 8'h00);
    expectVal("R1 mode", S_RD, A_MODE, 8'h00);
    expectVal("R1 cntLo", S_RD, A_CLO, 8'h00);
    expectVal("R1 rldHi", S_RD, A_RHI, 8'h00);
    expectVal("R1 irq", S_IRQ, 0, 0);
    expectVal("R1 rx", S_RX, 0, 0);
    expectVal("R1 tx", S_TX, 0, 0);

    // R13 register map
    regWrite(A_RLO, 8'h34);
    regWrite(A_RHI, 8'h12);
    expectVal("R13 rldLo", S_RD, A_RLO, 8'h34);
    expectVal("R13 rldHi", S_RD, A_RHI, 8'h12);
    regWrite(A_MODE, 8'hFF);
    expectVal("R13 mode unused bits", S_RD, A_MODE, 8'h03);
    regWrite(A_MODE, 8'h00);

    // R2 internal divide by twelve
    regWrite(A_CTRL, 8'h04);
    repeat (11) @(negedge clk);
    expectVal("R2 before 12th edge", S_RD, A_CLO, 8'h00);
    @(negedge clk);
    expectVal("R2 at 12th edge", S_RD, A_CLO, 8'h01);
    repeat (12) @(negedge clk);
    expectVal("R2 second tick", S_RD, A_CLO, 8'h02);

    // R4 stopped
    regWrite(A_CTRL, 8'h00);
    expectVal("R4 stop value", S_RD, A_CLO, 8'h02);
    repeat (30) @(negedge clk);
    expectVal("R4 held lo", S_RD, A_CLO, 8'h02);
    expectVal("R4 held hi", S_RD, A_CHI, 8'h00);

    // R3 external count
    regWrite(A_CTRL, 8'h06);
    pulseFall(1'b0);
    expectVal("R3 first fall", S_RD, A_CLO, 8'h03);
    pulseFall(1'b0);
    expectVal("R3 second fall", S_RD, A_CLO, 8'h04);

    // R5 capture-mode overflow wraps to zero
    regWrite(A_CLO, 8'hFE);
    regWrite(A_CHI, 8'hFF);
    regWrite(A_CTRL, 8'h07);
    pulseFall(1'b0);
    expectVal("R5 at max", S_RD, A_CLO, 8'hFF);
    pulseFall(1'b0);
    expectVal("R5 wrap lo", S_RD, A_CLO, 8'h00);
    expectVal("R5 wrap hi", S_RD, A_CHI, 8'h00);
    expectVal("R5 flag set", S_RD, A_CTRL, 8'h87);
    irqEn = 1'b1;
    expectVal("R12 irq on ovf", S_IRQ, 0, 1);
    irqEn = 1'b0;
    expectVal("R12 irq gated", S_IRQ, 0, 0);
    irqEn = 1'b1;
    regWrite(A_CTRL, 8'h07);
    expectVal("R5 flag cleared", S_RD, A_CTRL, 8'h07);
    expectVal("R5 irq cleared", S_IRQ, 0, 0);

    // R6 reload-mode overflow
    regWrite(A_CTRL, 8'h06);
    regWrite(A_CLO, 8'hFF);
    regWrite(A_CHI, 8'hFF);
    pulseFall(1'b0);
    expectVal("R6 reload lo", S_RD, A_CLO, 8'h34);
    expectVal("R6 reload hi", S_RD, A_CHI, 8'h12);
    expectVal("R6 flag", S_RD, A_CTRL, 8'h86);

    // R7 trigger capture
    regWrite(A_CTRL, 8'h0F);
    regWrite(A_CLO, 8'hBC);
    regWrite(A_CHI, 8'h0A);
    pulseFall(1'b1);
    expectVal("R7 cap lo", S_RD, A_RLO, 8'hBC);
    expectVal("R7 cap hi", S_RD, A_RHI, 8'h0A);
    expectVal("R7 count kept", S_RD, A_CLO, 8'hBC);
    expectVal("R7 ext flag", S_RD, A_CTRL, 8'h4F);
    expectVal("R12 irq on ext", S_IRQ, 0, 1);
    regWrite(A_MODE, 8'h01);
    expectVal("R12 ext masked", S_IRQ, 0, 0);
    regWrite(A_MODE, 8'h00);
    regWrite(A_CTRL, 8'h0F);
    expectVal("R7 flag cleared", S_RD, A_CTRL, 8'h0F);

    // R9 trigger disabled
    regWrite(A_CTRL, 8'h07);
    regWrite(A_CLO, 8'h55);
    regWrite(A_CHI, 8'h55);
    pulseFall(1'b1);
    expectVal("R9 no capture", S_RD, A_RLO, 8'hBC);
    expectVal("R9 no flag", S_RD, A_CTRL, 8'h07);
    regWrite(A_CTRL, 8'h06);
    pulseFall(1'b1);
    expectVal("R9 no reload", S_RD, A_CLO, 8'h55);

    // R8 trigger reload
    regWrite(A_RLO, 8'h22);
    regWrite(A_RHI, 8'h22);
    regWrite(A_CTRL, 8'h0E);
    regWrite(A_CLO, 8'h00);
    regWrite(A_CHI, 8'h01);
    pulseFall(1'b1);
    expectVal("R8 reload lo", S_RD, A_CLO, 8'h22);
    expectVal("R8 reload hi", S_RD, A_CHI, 8'h22);
    expectVal("R8 flag", S_RD, A_CTRL, 8'h4E);

    // R13 priority races
    regWrite(A_CTRL, 8'h0E);
    regWrite(A_RLO, 8'h33);
    regWrite(A_RHI, 8'h33);
    regWrite(A_CLO, 8'h00);
    @(negedge clk); trigPin = 1'b0;
    repeat (2) @(negedge clk);
    writeNow(A_CLO, 8'h77);
    expectVal("R13 reload beats write lo", S_RD, A_CLO, 8'h33);
    expectVal("R13 reload beats write hi", S_RD, A_CHI, 8'h33);
    trigPin = 1'b1;
    repeat (3) @(negedge clk);
    regWrite(A_CTRL, 8'h0E);
    @(negedge clk); trigPin = 1'b0;
    repeat (2) @(negedge clk);
    writeNow(A_CTRL, 8'h0E);
    expectVal("R13 set beats clear", S_RD, A_CTRL, 8'h4E);
    trigPin = 1'b1;
    repeat (3) @(negedge clk);

    // R10 receive baud
    irqEn = 1'b0;
    regWrite(A_RLO, 8'h00);
    regWrite(A_RHI, 8'h40);
    regWrite(A_CLO, 8'hFF);
    regWrite(A_CHI, 8'hFF);
    regWrite(A_CTRL, 8'h27);
    @(negedge clk); cntPin = 1'b0;
    repeat (3) @(negedge clk);
    expectVal("R10 rx pulse", S_RX, 0, 1);
    expectVal("R11 tx idle", S_TX, 0, 0);
    @(negedge clk);
    expectVal("R10 rx one cycle", S_RX, 0, 0);
    expectVal("R10 forced reload", S_RD, A_CHI, 8'h40);
    expectVal("R10 no ovf flag", S_RD, A_CTRL, 8'h27);
    cntPin = 1'b1;
    repeat (3) @(negedge clk);
    t1OvfIn = 1'b1;
    @(negedge clk);
    expectVal("R11 tx follows t1", S_TX, 0, 1);
    expectVal("R11 rx not t1", S_RX, 0, 0);
    t1OvfIn = 1'b0;
    @(negedge clk);
    expectVal("R11 tx low", S_TX, 0, 0);

    // R10 transmit baud
    regWrite(A_CTRL, 8'h16);
    regWrite(A_CLO, 8'hFF);
    regWrite(A_CHI, 8'hFF);
    @(negedge clk); cntPin = 1'b0;
    repeat (3) @(negedge clk);
    expectVal("R10 tx pulse", S_TX, 0, 1);
    expectVal("R11 rx idle", S_RX, 0, 0);
    cntPin = 1'b1;
    t1OvfIn = 1'b1;
    @(negedge clk);
    expectVal("R11 rx follows t1", S_RX, 0, 1);
    t1OvfIn = 1'b0;
    repeat (3) @(negedge clk);

    // R10 trigger in baud mode
    regWrite(A_CTRL, 8'h2E);
    regWrite(A_CLO, 8'h00);
    regWrite(A_CHI, 8'h05);
    pulseFall(1'b1);
    expectVal("R10 trig no reload", S_RD, A_CHI, 8'h05);
    expectVal("R10 trig no capture", S_RD, A_RHI, 8'h40);
    expectVal("R10 trig flag", S_RD, A_CTRL, 8'h6E);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule